// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry into an exception handler for a 32-bit processor core. It receives four pending requests: a bus fault and a software break raised by the core, and a non-maskable and a maskable interrupt raised from outside. It gates the external requests with their enable flags, picks the winner and its vector number, and computes the new values of the architectural registers. The register file and decoder stay outside. The block sees their current contents on input ports and returns the updated values together with write enables.

Once a request is accepted, all inputs are captured. The block then issues one read of the vector table through a valid/ready request and response port, at exception base plus four times the vector. The returned word becomes the new program counter. In the cycle after the read data arrives, `done` is high for one cycle. In that same cycle every result output is valid, and an acknowledge bit tells the requester which pending cause to clear. This keeps a later bus fault from being mistaken for a recursive one.

Top module: `exc_entry_seq`

## Requirements
- R1: When several requests are accepted together, the served cause is chosen in this order: bus fault, then break, then non-maskable interrupt, then maskable interrupt.
- R2: The vector number is `fault_vec` for a bus fault, `trap_vec` for a break, 0 for a non-maskable interrupt and `irq_vec` for a maskable interrupt.
- R3: A maskable interrupt is accepted only when status bit 5 (interrupt enable) is 1 and `irq_locked` is 0. A non-maskable interrupt is accepted only when its enable flag is 1. A request that is not accepted starts no table read and produces no `done`.
- R4: The non-maskable enable flag is status bit 7 when `version` is below 32, and status bit 9 otherwise.
- R5: The return address is written through `erp_we` for a break, a bus fault or a maskable interrupt, and through `nrp_we` for a non-maskable interrupt. A non-maskable entry clears its enable flag in the status word before the shift of R9.
- R6: The saved return address equals `pc_in` minus `dslot_off`. `dslot_clr` is high with `done` exactly when `dslot_off` was nonzero.
- R7: `exs_out` holds the low 8 bits of the vector in bits 15:8, and every other bit is 0.
- R8: When status bit 6 (user mode) is 1 at entry, `swap_we` is high with `done`, `usp_out` carries the old stack pointer and `sp_out` carries the kernel stack pointer. When bit 6 is 0, `swap_we` stays low.
- R9: `ccs_out` keeps old bits 31:30, places old bits 19:0 in bits 29:10, and has bits 9:0 equal to 0.
- R10: The table read address is `ebp_in` plus four times the vector, and `pc_out` at `done` equals the returned read data.
- R11: `rd_req_valid` and `rd_addr` hold until `rd_req_ready`. `done` rises in the cycle after `rd_resp_valid` and lasts exactly one cycle.
- R12: With `done`, `ack` is one-hot for the served cause: bit 0 maskable, bit 1 non-maskable, bit 2 break, bit 3 bus fault. At all other times `ack` is 0.
- R13: During and after reset, `rd_req_valid`, `done`, `ack` and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_irq | input | 1 | Maskable interrupt pending |
| req_nmi | input | 1 | Non-maskable interrupt pending |
| req_brk | input | 1 | Software break pending |
| req_bus | input | 1 | Bus fault pending |
| irq_locked | input | 1 | Maskable interrupts locked out |
| irq_vec | input | 8 | Vector from the interrupt controller |
| trap_vec | input | 8 | Programmable break vector |
| fault_vec | input | 8 | Vector latched at fault time |
| version | input | 8 | Core version number |
| pc_in | input | 32 | Current program counter |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| ccs_in | input | 32 | Current condition/status word |
| ebp_in | input | 32 | Exception table base |
| dslot_off | input | 2 | Delay-slot offset, 0 when not in a slot |
| rd_req_valid | output | 1 | Table read request valid |
| rd_req_ready | input | 1 | Table read request accepted |
| rd_addr | output | 32 | Table read address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data |
| done | output | 1 | Entry complete, results valid |
| ack | output | 4 | One-hot served cause |
| pc_out | output | 32 | Handler address for the PC |
| ret_addr | output | 32 | Return address to store |
| erp_we | output | 1 | Write return address to the exception return register |
| nrp_we | output | 1 | Write return address to the NMI return register |
| exs_out | output | 32 | Exception-status word |
| ccs_out | output | 32 | Shifted status word |
| swap_we | output | 1 | Perform stack pointer swap |
| usp_out | output | 32 | New user stack pointer |
| sp_out | output | 32 | New stack pointer |
| dslot_clr | output | 1 | Clear delay-slot state |

## Verification
The bench builds the block with its default parameters: 32-bit data, 8-bit vectors, a 2-bit delay-slot offset, interrupt enable at bit 5, user mode at bit 6, and the non-maskable flag at bit 7 or bit 9 with the split at version 32. These values let random versions fall on both sides of the split, including 31 and 32 exactly. The full offset range 0 to 3 is reachable, and the shifted status word shows the cleared enable flag at bit 17 or bit 19. Random delays on ready and on the response exercise the request hold and the wait state.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    CAUSE_IRQ = 2'd0,
    CAUSE_NMI = 2'd1,
    CAUSE_BRK = 2'd2,
    CAUSE_BUS = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VW        = 8,
  parameter int VERW      = 8,
  parameter int I_BIT     = 5,
  parameter int M_BIT_OLD = 7,
  parameter int M_BIT_NEW = 9,
  parameter int VER_SPLIT = 32
) (
  input  logic            req_irq,
  input  logic            req_nmi,
  input  logic            req_brk,
  input  logic            req_bus,
  input  logic            irq_locked,
  input  logic [XLEN-1:0] ccs,
  input  logic [VERW-1:0] version,
  input  logic [VW-1:0]   irq_vec,
  input  logic [VW-1:0]   trap_vec,
  input  logic [VW-1:0]   fault_vec,
  output logic            take,
  output cause_e          cause,
  output logic [VW-1:0]   vec,
  output logic [XLEN-1:0] m_mask
);
  logic nmi_ok, irq_ok;

  always_comb begin
    m_mask = (version < VERW'(VER_SPLIT)) ? (XLEN'(1) << M_BIT_OLD)
                                          : (XLEN'(1) << M_BIT_NEW);
    nmi_ok = req_nmi && ((ccs & m_mask) != '0);
    irq_ok = req_irq && ccs[I_BIT] && !irq_locked;
    take   = req_bus || req_brk || nmi_ok || irq_ok;
    if (req_bus) begin
      cause = CAUSE_BUS;
      vec   = fault_vec;
    end else if (req_brk) begin
      cause = CAUSE_BRK;
      vec   = trap_vec;
    end else if (nmi_ok) begin
      cause = CAUSE_NMI;
      vec   = '0;
    end else begin
      cause = CAUSE_IRQ;
      vec   = irq_vec;
    end
  end
endmodule

// File: rtl/exc_ccs_shift.sv
module exc_ccs_shift #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] ccs_old,
  output logic [XLEN-1:0] ccs_new
);
  localparam int KEEP  = 2;
  localparam int SHIFT = 10;
  localparam int FIELD = XLEN - KEEP - SHIFT;

  always_comb begin
    ccs_new = {ccs_old[XLEN-1 -: KEEP], ccs_old[FIELD-1:0], {SHIFT{1'b0}}};
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VW        = 8,
  parameter int VERW      = 8,
  parameter int DSW       = 2,
  parameter int I_BIT     = 5,
  parameter int U_BIT     = 6,
  parameter int M_BIT_OLD = 7,
  parameter int M_BIT_NEW = 9,
  parameter int VER_SPLIT = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_irq,
  input  logic            req_nmi,
  input  logic            req_brk,
  input  logic            req_bus,
  input  logic            irq_locked,
  input  logic [VW-1:0]   irq_vec,
  input  logic [VW-1:0]   trap_vec,
  input  logic [VW-1:0]   fault_vec,
  input  logic [VERW-1:0] version,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] sp_in,
  input  logic [XLEN-1:0] ksp_in,
  input  logic [XLEN-1:0] ccs_in,
  input  logic [XLEN-1:0] ebp_in,
  input  logic [DSW-1:0]  dslot_off,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  output logic [XLEN-1:0] rd_addr,
  input  logic            rd_resp_valid,
  input  logic [XLEN-1:0] rd_resp_data,
  output logic            done,
  output logic [3:0]      ack,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] ret_addr,
  output logic            erp_we,
  output logic            nrp_we,
  output logic [XLEN-1:0] exs_out,
  output logic [XLEN-1:0] ccs_out,
  output logic            swap_we,
  output logic [XLEN-1:0] usp_out,
  output logic [XLEN-1:0] sp_out,
  output logic            dslot_clr
);
  localparam int IDXW   = 8;
  localparam int IDXPOS = 8;
  localparam int NCAUSE = 4;

  // arbitration
  logic            take;
  cause_e          cause;
  logic [VW-1:0]   vec;
  logic [XLEN-1:0] m_mask;

  exc_arbiter #(
    .XLEN(XLEN), .VW(VW), .VERW(VERW), .I_BIT(I_BIT),
    .M_BIT_OLD(M_BIT_OLD), .M_BIT_NEW(M_BIT_NEW), .VER_SPLIT(VER_SPLIT)
  ) u_arb (
    .req_irq(req_irq), .req_nmi(req_nmi), .req_brk(req_brk), .req_bus(req_bus),
    .irq_locked(irq_locked), .ccs(ccs_in), .version(version),
    .irq_vec(irq_vec), .trap_vec(trap_vec), .fault_vec(fault_vec),
    .take(take), .cause(cause), .vec(vec), .m_mask(m_mask)
  );

  // status word: drop the NMI enable for NMI entry, then push
  logic [XLEN-1:0] ccs_work, ccs_shifted;
  always_comb begin
    ccs_work = (cause == CAUSE_NMI) ? (ccs_in & ~m_mask) : ccs_in;
  end

  exc_ccs_shift #(.XLEN(XLEN)) u_shift (
    .ccs_old(ccs_work),
    .ccs_new(ccs_shifted)
  );

  // registers
  state_e          state_q, state_d;
  logic            done_q, done_d;
  logic            cap_en, pc_en;
  cause_e          cause_q;
  logic [XLEN-1:0] ret_q, exs_q, ccs_q, usp_q, ksp_q, addr_q, pc_q;
  logic            swap_q, ds_q;

  // next state
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    cap_en  = 1'b0;
    pc_en   = 1'b0;
    case (state_q)
      ST_IDLE: if (take && !done_q) begin
        cap_en  = 1'b1;
        state_d = ST_REQ;
      end
      ST_REQ:  if (rd_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (rd_resp_valid) begin
        pc_en   = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_IRQ;
      ret_q   <= '0;
      exs_q   <= '0;
      ccs_q   <= '0;
      usp_q   <= '0;
      ksp_q   <= '0;
      addr_q  <= '0;
      swap_q  <= 1'b0;
      ds_q    <= 1'b0;
    end else if (cap_en) begin
      cause_q <= cause;
      ret_q   <= pc_in - XLEN'(dslot_off);
      exs_q   <= XLEN'(vec[IDXW-1:0]) << IDXPOS;
      ccs_q   <= ccs_shifted;
      usp_q   <= sp_in;
      ksp_q   <= ksp_in;
      addr_q  <= ebp_in + (XLEN'(vec) << 2);
      swap_q  <= ccs_in[U_BIT];
      ds_q    <= (dslot_off != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (pc_en) pc_q <= rd_resp_data;
  end

  // outputs
  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_addr      = addr_q;
  assign done         = done_q;
  assign pc_out       = pc_q;
  assign ret_addr     = ret_q;
  assign erp_we       = done_q && (cause_q != CAUSE_NMI);
  assign nrp_we       = done_q && (cause_q == CAUSE_NMI);
  assign exs_out      = exs_q;
  assign ccs_out      = ccs_q;
  assign swap_we      = done_q && swap_q;
  assign usp_out      = usp_q;
  assign sp_out       = ksp_q;
  assign dslot_clr    = done_q && ds_q;

  for (genvar g = 0; g < NCAUSE; g++) begin : g_ack
    assign ack[g] = done_q && (cause_q == cause_e'(g));
  end

  // checks
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr))); // R11
  AST_DONE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rd_resp_valid)); // R11
  AST_ONE_RET_REG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({erp_we, nrp_we})); // R5
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack) && (done == (ack != 4'b0))); // R12
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_irq, req_nmi, req_brk, req_bus, irq_locked;
  logic [7:0]  irq_vec, trap_vec, fault_vec, version;
  logic [31:0] pc_in, sp_in, ksp_in, ccs_in, ebp_in;
  logic [1:0]  dslot_off;
  logic        rd_req_valid, rd_req_ready, rd_resp_valid;
  logic [31:0] rd_addr, rd_resp_data;
  logic        done, erp_we, nrp_we, swap_we, dslot_clr;
  logic [3:0]  ack;
  logic [31:0] pc_out, ret_addr, exs_out, ccs_out, usp_out, sp_out;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n),
    .req_irq(req_irq), .req_nmi(req_nmi), .req_brk(req_brk), .req_bus(req_bus),
    .irq_locked(irq_locked), .irq_vec(irq_vec), .trap_vec(trap_vec),
    .fault_vec(fault_vec), .version(version), .pc_in(pc_in), .sp_in(sp_in),
    .ksp_in(ksp_in), .ccs_in(ccs_in), .ebp_in(ebp_in), .dslot_off(dslot_off),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .done(done), .ack(ack), .pc_out(pc_out), .ret_addr(ret_addr),
    .erp_we(erp_we), .nrp_we(nrp_we), .exs_out(exs_out), .ccs_out(ccs_out),
    .swap_we(swap_we), .usp_out(usp_out), .sp_out(sp_out), .dslot_clr(dslot_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] push_ccs(input logic [31:0] c);
    return {c[31:30], c[19:0], 10'b0};
  endfunction

  // cause codes: 0 irq, 1 nmi, 2 brk, 3 bus, -1 none
  task automatic run_case(input bit irq, input bit nmi, input bit brk, input bit bus,
                          input bit lock, input logic [31:0] ccs, input logic [7:0] ver,
                          input logic [1:0] off, input string tag);
    int m_pos, cause, vec;
    logic [31:0] ccs_w, exp_addr, exp_data;
    bit got, sent, fin;
    int dly;
    @(negedge clk);
    req_irq = irq; req_nmi = nmi; req_brk = brk; req_bus = bus;
    irq_locked = lock; ccs_in = ccs; version = ver; dslot_off = off;
    irq_vec = 8'($urandom); trap_vec = 8'($urandom); fault_vec = 8'($urandom);
    pc_in = $urandom; sp_in = $urandom; ksp_in = $urandom; ebp_in = $urandom;
    // R4 flag position, R3 gating, R1 priority, R2 vector
    m_pos = (ver < 8'd32) ? 7 : 9;
    if (bus) begin cause = 3; vec = fault_vec; end
    else if (brk) begin cause = 2; vec = trap_vec; end
    else if (nmi && ccs[m_pos]) begin cause = 1; vec = 0; end
    else if (irq && ccs[5] && !lock) begin cause = 0; vec = irq_vec; end
    else begin cause = -1; vec = 0; end
    ccs_w = ccs;
    if (cause == 1) ccs_w[m_pos] = 1'b0;
    exp_addr = ebp_in + 32'(vec) * 4;
    exp_data = mem_word(exp_addr);
    rd_req_ready = 1'b0; rd_resp_valid = 1'b0;
    if (cause < 0) begin
      bit seen = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (rd_req_valid || done) seen = 1;
      end
      chk({"R3 rejected ", tag}, 32'(seen), 32'd0);
    end else begin
      got = 0; sent = 0; fin = 0; dly = 0;
      for (int i = 0; i < 60 && !fin; i++) begin
        @(negedge clk);
        rd_resp_valid = 1'b0;
        if (done) begin
          fin = 1;
          chk({"R1 ack ", tag}, 32'(ack), 32'(1) << cause);
          chk({"R12 ack onehot ", tag}, 32'($countones(ack)), 32'd1);
          chk({"R10 pc ", tag}, pc_out, exp_data);
          chk({"R6 ret ", tag}, ret_addr, pc_in - 32'(off));
          chk({"R6 dslot_clr ", tag}, 32'(dslot_clr), 32'(off != 2'd0));
          chk({"R5 erp_we ", tag}, 32'(erp_we), 32'(cause != 1));
          chk({"R5 nrp_we ", tag}, 32'(nrp_we), 32'(cause == 1));
          chk({"R7 exs ", tag}, exs_out, 32'(vec[7:0]) << 8);
          chk({"R9 ccs ", tag}, ccs_out, push_ccs(ccs_w));
          chk({"R8 swap_we ", tag}, 32'(swap_we), 32'(ccs[6]));
          if (ccs[6]) begin
            chk({"R8 usp ", tag}, usp_out, sp_in);
            chk({"R8 sp ", tag}, sp_out, ksp_in);
          end
          req_irq = 0; req_nmi = 0; req_brk = 0; req_bus = 0;
          rd_req_ready = 1'b0;
        end else begin
          if (got && !sent) begin
            if (dly == 0) begin
              rd_resp_valid = 1'b1;
              rd_resp_data = exp_data;
              sent = 1;
            end else begin
              dly--;
              rd_resp_data = $urandom;
            end
          end
          rd_req_ready = 1'($urandom);
          if (rd_req_valid && rd_req_ready && !got) begin
            chk({"R10 addr ", tag}, rd_addr, exp_addr);
            got = 1;
            dly = $urandom % 4;
          end
        end
      end
      chk({"R11 completed ", tag}, 32'(fin), 32'd1);
      @(negedge clk);
      chk({"R11 done one cycle ", tag}, 32'(done), 32'd0);
      chk({"R12 ack idle ", tag}, 32'(ack), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_irq = 0; req_nmi = 0; req_brk = 0; req_bus = 0; irq_locked = 0;
    irq_vec = 0; trap_vec = 0; fault_vec = 0; version = 0;
    pc_in = 0; sp_in = 0; ksp_in = 0; ccs_in = 0; ebp_in = 0; dslot_off = 0;
    rd_req_ready = 0; rd_resp_valid = 0; rd_resp_data = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 req", 32'(rd_req_valid), 32'd0);
    chk("R13 done", 32'(done), 32'd0);
    chk("R13 we", 32'({ack, erp_we, nrp_we, swap_we, dslot_clr}), 32'd0);
    rst_n = 1'b1;

    // directed corners
    run_case(1, 0, 0, 0, 0, 32'h0000_0020, 8'd40, 2'd0, "irq plain");
    run_case(1, 0, 0, 0, 0, 32'h0000_0000, 8'd40, 2'd0, "irq I clear");
    run_case(1, 0, 0, 0, 1, 32'h0000_0020, 8'd40, 2'd0, "irq locked");
    run_case(0, 1, 0, 0, 0, 32'h0000_0080, 8'd31, 2'd0, "nmi old pos");
    run_case(0, 1, 0, 0, 0, 32'h0000_0080, 8'd32, 2'd0, "nmi old pos on new core");
    run_case(0, 1, 0, 0, 0, 32'hC00F_F2A0, 8'd32, 2'd1, "nmi new pos");
    run_case(1, 1, 0, 0, 0, 32'h0000_02A0, 8'd50, 2'd0, "nmi beats irq");
    run_case(1, 1, 1, 0, 0, 32'h0000_02A0, 8'd50, 2'd3, "brk beats nmi");
    run_case(1, 1, 1, 1, 0, 32'hFFFF_FFFF, 8'd10, 2'd2, "bus beats all");
    run_case(0, 0, 1, 0, 0, 32'h8003_5440, 8'd5, 2'd0, "brk user mode");

    // random mix
    for (int n = 0; n < 300; n++) begin
      run_case(1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0,
               ($urandom % 4) == 0, $urandom, 8'($urandom % 64), 2'($urandom),
               "random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule